// File: doc/BRIEF.md
# Two-Lane ADC Ramp Pattern Checker

This block watches an ADC sample stream while the converter sends a counting ramp as a test pattern. The in-phase (I) lane and the quadrature (Q) lane are checked on their own. Each lane starts out hunting. The first valid zero sample on a lane locks that lane. From then on the lane predicts that every valid sample is one more than the last prediction, wrapping at the sample width. Each valid sample that differs from the prediction adds one to that lane's error count. The count stops at its maximum value and does not wrap.

A host runs a test in three steps. It drops the enable, raises it again, waits a fixed time, and then reads the two locked flags and the two error counts. During the test, one lane usually carries the ramp and the other is tied to all ones. The all-ones lane never contains a zero, so it stays unlocked and cannot report a false match.

Top module: `adc_ramp_checker`

## Requirements
- R1: After reset, both locked flags read 0 and both error counts read 0.
- R2: A lane sets its locked flag only after a clock edge at which `smp_valid` is 1 and that lane's sample is zero. A cycle with `smp_valid` at 0 changes no lane state, locked or not.
- R3: Once a lane locks, its first expected value is 1. Each further valid sample advances the expectation by one, so a clean ramp leaves the count at 0.
- R4: Each valid sample that differs from the expectation raises that lane's error count by exactly one, one cycle later. The expectation keeps advancing by one whether or not the sample matched.
- R5: The expectation wraps from all ones (15 when SAMPLE_W is 4) to zero, and the wrap itself is not counted as an error.
- R6: The error count saturates at 2^ERR_W-1 (7 when ERR_W is 3) and stays there while further mismatches arrive.
- R7: The two lanes lock and count independently. A lane that carries all ones never locks and never counts.
- R8: While `en` is 0, both locked flags and both counts read 0 in that same cycle. After `en` returns to 1, each lane needs a new zero sample to lock, and counting starts again from 0.
- R9: While `en` stays at 1, a locked lane stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| en | input | 1 | Checker enable; taking it low and then high again starts a new test |
| smp_valid | input | 1 | Marks a cycle that carries a sample on both lanes |
| i_smp | input | SAMPLE_W | In-phase lane sample |
| q_smp | input | SAMPLE_W | Quadrature lane sample |
| i_locked | output | 1 | In-phase lane has locked onto the ramp |
| i_errs | output | ERR_W | In-phase lane mismatch count, saturating |
| q_locked | output | 1 | Quadrature lane has locked onto the ramp |
| q_errs | output | ERR_W | Quadrature lane mismatch count, saturating |

## Verification
The bench builds the block with SAMPLE_W = 4 and ERR_W = 3. This lets a whole ramp period, including the wrap from 15 to 0, run in sixteen samples. It also lets the count reach saturation at 7 after only a handful of deliberate mismatches. With these widths, the bench can cover the wrap, the saturation limit, the lane-to-lane independence, and re-arming through the enable in a short run.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;
  typedef enum logic {
    LANE_HUNT  = 1'b0,
    LANE_TRACK = 1'b1
  } lane_mode_e;

  localparam int unsigned LANE_I = 0;
  localparam int unsigned LANE_Q = 1;
  localparam int unsigned LANE_COUNT = 2;
endpackage

// File: rtl/ramp_rst_sync.sv
module ramp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/ramp_lane_track.sv
module ramp_lane_track
  import adc_ramp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                locked,
  output logic                miss
);
  localparam logic [SAMPLE_W-1:0] RAMP_ZERO = '0;
  localparam logic [SAMPLE_W-1:0] RAMP_STEP = {{(SAMPLE_W-1){1'b0}}, 1'b1};

  lane_mode_e          mode_q, mode_d;
  logic [SAMPLE_W-1:0] expect_q, expect_d;
  logic                upd_en;

  // Registers only move on a valid sample, or while held in the disarmed state.
  assign upd_en = !arm || valid;

  always_comb begin
    mode_d   = mode_q;
    expect_d = expect_q;
    if (!arm) begin
      mode_d   = LANE_HUNT;
      expect_d = RAMP_ZERO;
    end else if (valid) begin
      case (mode_q)
        LANE_HUNT: begin
          if (sample == RAMP_ZERO) begin
            mode_d   = LANE_TRACK;
            expect_d = RAMP_STEP;
          end
        end
        LANE_TRACK: begin
          expect_d = expect_q + RAMP_STEP;
        end
        default: begin
          mode_d   = LANE_HUNT;
          expect_d = RAMP_ZERO;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= LANE_HUNT;
      expect_q <= RAMP_ZERO;
    end else if (upd_en) begin
      mode_q   <= mode_d;
      expect_q <= expect_d;
    end
  end

  assign locked = arm && (mode_q == LANE_TRACK);
  assign miss   = arm && valid && (mode_q == LANE_TRACK) && (sample != expect_q);
endmodule

// File: rtl/ramp_sat_count.sv
module ramp_sat_count #(
  parameter int unsigned ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [ERR_W-1:0] count
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;
  localparam logic [ERR_W-1:0] CNT_ONE = {{(ERR_W-1){1'b0}}, 1'b1};

  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr || (inc && (cnt_q != CNT_MAX));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/adc_ramp_checker.sv
module adc_ramp_checker
  import adc_ramp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ERR_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] i_smp,
  input  logic [SAMPLE_W-1:0] q_smp,
  output logic                i_locked,
  output logic [ERR_W-1:0]    i_errs,
  output logic                q_locked,
  output logic [ERR_W-1:0]    q_errs
);
  localparam int unsigned NLANE = LANE_COUNT;

  logic                rst_int_n;
  logic [SAMPLE_W-1:0] lane_smp  [NLANE];
  logic                lane_lock [NLANE];
  logic                lane_miss [NLANE];
  logic [ERR_W-1:0]    lane_cnt  [NLANE];

  ramp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign lane_smp[LANE_I] = i_smp;
  assign lane_smp[LANE_Q] = q_smp;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    ramp_lane_track #(.SAMPLE_W(SAMPLE_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .arm    (en),
      .valid  (smp_valid),
      .sample (lane_smp[g]),
      .locked (lane_lock[g]),
      .miss   (lane_miss[g])
    );

    ramp_sat_count #(.ERR_W(ERR_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (!en),
      .inc   (lane_miss[g]),
      .count (lane_cnt[g])
    );
  end

  assign i_locked = lane_lock[LANE_I];
  assign q_locked = lane_lock[LANE_Q];
  assign i_errs   = en ? lane_cnt[LANE_I] : '0;
  assign q_errs   = en ? lane_cnt[LANE_Q] : '0;
endmodule

// File: rtl/adc_ramp_checker_sva.sv
module adc_ramp_checker_sva #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned ERR_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] i_smp,
  input logic [SAMPLE_W-1:0] q_smp,
  input logic                i_locked,
  input logic [ERR_W-1:0]    i_errs,
  input logic                q_locked,
  input logic [ERR_W-1:0]    q_errs
);
  localparam logic [ERR_W-1:0] EMAX = '1;
  localparam logic [ERR_W-1:0] EONE = {{(ERR_W-1){1'b0}}, 1'b1};

  assert_i_lock_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_locked) |-> $past(smp_valid && (i_smp == '0)));
  assert_q_lock_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_locked) |-> $past(smp_valid && (q_smp == '0)));

  assert_i_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ((i_errs == $past(i_errs)) || (i_errs == $past(i_errs) + EONE)));
  assert_q_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ((q_errs == $past(q_errs)) || (q_errs == $past(q_errs) + EONE)));

  assert_i_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && ($past(i_errs) == EMAX)) |-> (i_errs == EMAX));
  assert_q_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && ($past(q_errs) == EMAX)) |-> (q_errs == EMAX));

  assert_unlocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !i_locked) |-> (i_errs == '0));

  assert_rearm_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (!i_locked && !q_locked && (i_errs == '0) && (q_errs == '0)));

  assert_i_hold_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(i_locked)) |-> i_locked);
  assert_q_hold_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(q_locked)) |-> q_locked);
endmodule

bind adc_ramp_checker adc_ramp_checker_sva #(
  .SAMPLE_W(SAMPLE_W),
  .ERR_W   (ERR_W)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .smp_valid (smp_valid),
  .i_smp     (i_smp),
  .q_smp     (q_smp),
  .i_locked  (i_locked),
  .i_errs    (i_errs),
  .q_locked  (q_locked),
  .q_errs    (q_errs)
);

// File: tb/adc_ramp_checker_tb.sv
module adc_ramp_checker_tb;
  localparam int unsigned SAMPLE_W   = 4;
  localparam int unsigned ERR_W      = 3;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NVEC       = 14;

  // {en, valid, i, q, exp i_locked, exp i_errs, exp q_locked, exp q_errs}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 4'd0,  4'd0,  1'b0, 3'd0, 1'b0, 3'd0},  // R8 disabled
    {1'b1, 1'b1, 4'd5,  4'd15, 1'b0, 3'd0, 1'b0, 3'd0},  // R2 no zero
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b0, 3'd0, 1'b0, 3'd0},  // R2 invalid zero
    {1'b1, 1'b1, 4'd0,  4'd15, 1'b1, 3'd0, 1'b0, 3'd0},  // R2 I locks, R7
    {1'b1, 1'b1, 4'd1,  4'd15, 1'b1, 3'd0, 1'b0, 3'd0},  // R3
    {1'b1, 1'b1, 4'd2,  4'd0,  1'b1, 3'd0, 1'b1, 3'd0},  // R3, R7 Q locks
    {1'b1, 1'b1, 4'd7,  4'd1,  1'b1, 3'd1, 1'b1, 3'd0},  // R4 I miss
    {1'b1, 1'b1, 4'd4,  4'd2,  1'b1, 3'd1, 1'b1, 3'd0},  // R4 free-running
    {1'b1, 1'b0, 4'd9,  4'd9,  1'b1, 3'd1, 1'b1, 3'd0},  // R2 invalid ignored
    {1'b1, 1'b1, 4'd5,  4'd3,  1'b1, 3'd1, 1'b1, 3'd0},  // R9
    {1'b1, 1'b1, 4'd0,  4'd3,  1'b1, 3'd2, 1'b1, 3'd1},  // R4 both miss
    {1'b0, 1'b1, 4'd7,  4'd5,  1'b0, 3'd0, 1'b0, 3'd0},  // R8 clear
    {1'b1, 1'b1, 4'd7,  4'd5,  1'b0, 3'd0, 1'b0, 3'd0},  // R8 needs zero
    {1'b1, 1'b1, 4'd0,  4'd0,  1'b1, 3'd0, 1'b1, 3'd0}   // R8 relock
  };

  logic                clk;
  logic                rst_n;
  logic                en;
  logic                smp_valid;
  logic [SAMPLE_W-1:0] i_smp;
  logic [SAMPLE_W-1:0] q_smp;
  logic                i_locked;
  logic [ERR_W-1:0]    i_errs;
  logic                q_locked;
  logic [ERR_W-1:0]    q_errs;

  int n_cmp;
  int n_bad;
  bit done;

  adc_ramp_checker #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
    .i_smp(i_smp), .q_smp(q_smp),
    .i_locked(i_locked), .i_errs(i_errs),
    .q_locked(q_locked), .q_errs(q_errs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic v, input int iv, input int qv);
    @(negedge clk);
    en        = e;
    smp_valid = v;
    i_smp     = SAMPLE_W'(iv);
    q_smp     = SAMPLE_W'(qv);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; en = 1'b0; smp_valid = 1'b0; i_smp = '0; q_smp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); en = 1'b1;
    #1;
    // R1 reset state
    chk("R1 i_locked", i_locked, 0);
    chk("R1 i_errs", i_errs, 0);
    chk("R1 q_locked", q_locked, 0);
    chk("R1 q_errs", q_errs, 0);

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][17], VEC[k][16], VEC[k][15:12], VEC[k][11:8]);
      chk($sformatf("vec%0d i_locked", k), i_locked, VEC[k][7]);
      chk($sformatf("vec%0d i_errs", k), i_errs, VEC[k][6:4]);
      chk($sformatf("vec%0d q_locked", k), q_locked, VEC[k][3]);
      chk($sformatf("vec%0d q_errs", k), q_errs, VEC[k][2:0]);
    end

    // R5 wrap: full ramp period and beyond on I, Q tied to all ones (R7)
    drive(1'b0, 1'b0, 0, 15);
    for (int s = 0; s < 19; s++) drive(1'b1, 1'b1, s % 16, 15);
    chk("R5 i_locked after wrap", i_locked, 1);
    chk("R5 i_errs after wrap", i_errs, 0);
    chk("R7 q_locked all ones", q_locked, 0);
    chk("R7 q_errs all ones", q_errs, 0);

    // R6 saturation on Q: lock, then 12 mismatches (15 never equals 1..12)
    drive(1'b1, 1'b1, 3, 0);
    for (int s = 0; s < 12; s++) drive(1'b1, 1'b1, 4 + s, 15);
    chk("R6 q_errs saturated", q_errs, 7);
    chk("R9 q_locked held", q_locked, 1);
    chk("R4 i_errs clean ramp", i_errs, 0);
    drive(1'b1, 1'b1, 0, 15);
    chk("R6 q_errs stays", q_errs, 7);

    // R8 same-cycle clear while en low
    @(negedge clk); en = 1'b0; smp_valid = 1'b0; #1;
    chk("R8 q_errs immediate", q_errs, 0);
    chk("R8 q_locked immediate", q_locked, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule